// File: doc/BRIEF.md
# MRU-Bit Replacement Translation Lookaside Buffer

This block is a small, fully associative translation buffer. It caches mappings from virtual page numbers to physical frame numbers, each with read, write and execute permission flags. A lookup presents a virtual page number, a page offset and an access kind. In the same cycle the block answers with a hit, a permission fault or a miss. On a hit it also gives the frame number and the full physical address.

A fill port installs a translation that was fetched elsewhere, and an invalidate port drops one page. Replacement keeps one recently-used bit per entry. A hit on a full buffer wipes every other bit. A fill that brings the buffer to full occupancy starts the bits over from zero. When the buffer is full, a fill overwrites the lowest-numbered entry whose bit is clear.

Three saturating counters record successful translations, misses and evictions.

Top module: `tlb_mru`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and all three counters read zero.
- R2: A lookup whose page matches a valid entry with sufficient permission drives `lk_hit`=1 and `lk_pfn` to the entry's frame. It drives `lk_paddr` = {frame, `lk_offset`}, where the offset is OFF_W (12) bits wide.
- R3: A lookup that matches no valid entry drives `lk_hit`=0, `lk_fault`=0, `lk_pfn`=0 and `lk_paddr`=0. With `lk_valid` low, both `lk_hit` and `lk_fault` are 0.
- R4: Permission field bit 0 = R, bit 1 = W, bit 2 = X. The access kinds are: 0 = fetch, which needs R and X; 1 = load and 3 = load, which need R; 2 = store, which needs W. A match without the needed bits drives `lk_fault`=1, `lk_hit`=0 and a zero frame and address.
- R5: A fill of a page that is not resident, into a buffer that is not full, takes the lowest free slot without evicting. A fill of a resident page rewrites its frame and flags in place and evicts nothing.
- R6: Any match, including a faulting one, sets that entry's recently-used bit at the next edge. If the buffer is full, the same edge clears every other bit.
- R7: A fill that arrives with exactly N-1 entries valid clears all recently-used bits before the new entry is installed. New entries always start with the bit clear.
- R8: A fill of a new page into a full buffer replaces the lowest-indexed entry whose recently-used bit is clear. If every bit is set, it replaces entry 0.
- R9: An invalidate removes the valid entry with the matching page. Later lookups of that page miss, and its slot is reused by the next fill without an eviction.
- R10: When a fill and a matching lookup occur in the same cycle, the fill is applied and the lookup's recently-used update is dropped. The lookup outputs in that cycle are still correct.
- R11: The hit counter counts lookups with `lk_hit`=1. The miss counter counts valid lookups that match no entry. The eviction counter counts fills that replace a valid entry. Each counter stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| lk_offset | input | OFF_W | Page offset of the access |
| lk_hit | output | 1 | Translation valid and permitted |
| lk_fault | output | 1 | Page resident but permission denied |
| lk_pfn | output | PFN_W | Frame number, zero unless hit |
| lk_paddr | output | PFN_W+OFF_W | Physical address, zero unless hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page to install |
| fill_pfn | input | PFN_W | Frame to install |
| fill_perm | input | 3 | Flags: bit 0 R, bit 1 W, bit 2 X |
| inv_en | input | 1 | Invalidate request |
| inv_vpn | input | VPN_W | Page to invalidate |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| evict_count | output | CNT_W | Saturating eviction counter |

## Verification
The bench builds the block with four entries, 8-bit pages, 10-bit frames and 4-bit counters. Four entries make every occupancy step reachable in a few fills: empty, N-1 with the bulk clear, and full with eviction. Each victim choice is then visible through which page misses next. The 4-bit counters reach their saturation ceiling after about twenty requests, which would be out of reach at the default 32-bit width.

// File: rtl/tlb_mru.sv
module tlb_mru #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 22,
  parameter int OFF_W = 12,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [1:0]             lk_kind,
  input  logic [OFF_W-1:0]       lk_offset,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PFN_W-1:0]       lk_pfn,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [2:0]             fill_perm,
  input  logic                   inv_en,
  input  logic [VPN_W-1:0]       inv_vpn,
  output logic [CNT_W-1:0]       hit_count,
  output logic [CNT_W-1:0]       miss_count,
  output logic [CNT_W-1:0]       evict_count
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int OCC_W = IDX_W + 1;
  localparam logic [OCC_W-1:0] ALMOST = OCC_W'(N - 1);

  logic [N-1:0]       valid, mru, valid_nx, mru_nx;
  logic [VPN_W-1:0]   vpn_q  [N];
  logic [PFN_W-1:0]   pfn_q  [N];
  logic [2:0]         perm_q [N];

  logic [N-1:0]       lk_vec, fl_vec, inv_vec;
  logic [IDX_W-1:0]   lk_idx, fl_idx, free_idx, vic_idx, tgt_idx;
  logic [OCC_W-1:0]   occ;
  logic               match, allowed, full, resident, evicting;
  logic [2:0]         sel_perm;

  always_comb begin
    lk_idx   = '0;
    fl_idx   = '0;
    free_idx = '0;
    vic_idx  = '0;
    occ      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      lk_vec[i]  = valid[i] && (vpn_q[i] == lk_vpn);
      fl_vec[i]  = valid[i] && (vpn_q[i] == fill_vpn);
      inv_vec[i] = valid[i] && (vpn_q[i] == inv_vpn);
      if (lk_vec[i]) lk_idx = IDX_W'(i);
      if (fl_vec[i]) fl_idx = IDX_W'(i);
      if (!valid[i]) free_idx = IDX_W'(i);
      if (!mru[i])   vic_idx  = IDX_W'(i);
      occ = occ + OCC_W'(valid[i]);
    end
  end

  assign full     = &valid;
  assign match    = lk_valid && |lk_vec;
  assign sel_perm = perm_q[lk_idx];

  always_comb begin
    unique case (lk_kind)
      2'd0:    allowed = sel_perm[0] && sel_perm[2];
      2'd2:    allowed = sel_perm[1];
      default: allowed = sel_perm[0];
    endcase
  end

  assign lk_hit   = match && allowed;
  assign lk_fault = match && !allowed;
  assign lk_pfn   = lk_hit ? pfn_q[lk_idx] : '0;
  assign lk_paddr = lk_hit ? {pfn_q[lk_idx], lk_offset} : '0;

  assign resident = |fl_vec;
  assign tgt_idx  = resident ? fl_idx : (full ? vic_idx : free_idx);
  assign evicting = fill_en && !resident && full;

  always_comb begin
    valid_nx = valid;
    mru_nx   = mru;
    if (fill_en) begin
      if (!resident) begin
        if (occ == ALMOST) mru_nx = '0;
        mru_nx[tgt_idx]   = 1'b0;
        valid_nx[tgt_idx] = 1'b1;
      end
    end else if (match) begin
      if (full) mru_nx = '0;
      mru_nx[lk_idx] = 1'b1;
    end
    if (inv_en) begin
      valid_nx = valid_nx & ~inv_vec;
      mru_nx   = mru_nx & ~inv_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      mru   <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      valid <= valid_nx;
      mru   <= mru_nx;
      if (fill_en) begin
        vpn_q[tgt_idx]  <= fill_vpn;
        pfn_q[tgt_idx]  <= fill_pfn;
        perm_q[tgt_idx] <= fill_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
    end else begin
      if (lk_hit && !(&hit_count)) hit_count <= hit_count + 1'b1;
      if (lk_valid && !(|lk_vec) && !(&miss_count)) miss_count <= miss_count + 1'b1;
      if (evicting && !(&evict_count)) evict_count <= evict_count + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_mru_chk.sv
module tlb_mru_chk #(
  parameter int PFN_W = 22,
  parameter int OFF_W = 12,
  parameter int CNT_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [OFF_W-1:0]       lk_offset,
  input logic                   lk_hit,
  input logic                   lk_fault,
  input logic [PFN_W-1:0]       lk_pfn,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_en,
  input logic [CNT_W-1:0]       hit_count,
  input logic [CNT_W-1:0]       evict_count
);
  a_r4_fault_excludes_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fault));

  a_r3_zero_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0 && lk_paddr == '0));

  a_r2_paddr_layout: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_offset && lk_paddr[PFN_W+OFF_W-1:OFF_W] == lk_pfn));

  a_r11_evict_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $stable(evict_count));

  a_r11_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && hit_count != '1) |=> hit_count == $past(hit_count) + 1'b1);

  a_r11_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |=> $stable(hit_count));
endmodule

bind tlb_mru tlb_mru_chk #(.PFN_W(PFN_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_offset(lk_offset),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pfn(lk_pfn), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .hit_count(hit_count), .evict_count(evict_count)
);

// File: tb/tlb_mru_test.sv
module tlb_mru_test;
  localparam int N = 4, VW = 8, PW = 10, OW = 12, CW = 4;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, inv_en = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [1:0] lk_kind = '0;
  logic [OW-1:0] lk_offset = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [2:0] fill_perm = '0;
  logic lk_hit, lk_fault;
  logic [PW-1:0] lk_pfn;
  logic [PW+OW-1:0] lk_paddr;
  logic [CW-1:0] hit_count, miss_count, evict_count;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  tlb_mru #(.N(N), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
    .lk_offset(lk_offset), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
    .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .inv_en(inv_en), .inv_vpn(inv_vpn), .hit_count(hit_count),
    .miss_count(miss_count), .evict_count(evict_count));

  // {vpn, kind, offset, hit, fault, pfn}
  localparam logic [33:0] VEC [9] = '{
    {8'h10, 2'd1, 12'h0AB, 1'b1, 1'b0, 10'h100},
    {8'h11, 2'd2, 12'h001, 1'b0, 1'b1, 10'h000},
    {8'h11, 2'd1, 12'hFFF, 1'b1, 1'b0, 10'h101},
    {8'h12, 2'd2, 12'h000, 1'b1, 1'b0, 10'h102},
    {8'h12, 2'd1, 12'h010, 1'b0, 1'b1, 10'h000},
    {8'h10, 2'd0, 12'h123, 1'b1, 1'b0, 10'h100},
    {8'h11, 2'd0, 12'h044, 1'b0, 1'b1, 10'h000},
    {8'h33, 2'd1, 12'h555, 1'b0, 1'b0, 10'h000},
    {8'h12, 2'd3, 12'h777, 1'b0, 1'b1, 10'h000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_exp(input logic h, input logic f, input logic [PW-1:0] p,
                                           input logic [OW-1:0] o);
    return {h, f, p, (h ? {p, o} : {(PW+OW){1'b0}})};
  endfunction

  task automatic drive_look(input logic [VW-1:0] v, input logic [1:0] k, input logic [OW-1:0] o);
    lk_valid = 1; lk_vpn = v; lk_kind = k; lk_offset = o;
  endtask

  task automatic look(input string tag, input logic [VW-1:0] v, input logic [1:0] k,
                      input logic [OW-1:0] o, input logic eh, input logic ef, input logic [PW-1:0] ep);
    @(negedge clk);
    drive_look(v, k, o);
    #2 check(tag, {lk_hit, lk_fault, lk_pfn, lk_paddr}, pack_exp(eh, ef, ep, o));
    @(posedge clk); #1 lk_valid = 0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [2:0] pm);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_perm = pm;
    @(posedge clk); #1 fill_en = 0;
  endtask

  task automatic inval(input logic [VW-1:0] v);
    @(negedge clk);
    inv_en = 1; inv_vpn = v;
    @(posedge clk); #1 inv_en = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check("R1 counters after reset", {hit_count, miss_count, evict_count}, '0);
    look("R1 R3 empty buffer misses", 8'h05, 2'd1, 12'h3C4, 1'b0, 1'b0, '0);

    // R5: three fills into free slots 0,1,2
    fill(8'h10, 10'h100, 3'b111);
    fill(8'h11, 10'h101, 3'b001);
    fill(8'h12, 10'h102, 3'b010);

    // R2 R3 R4: vector table
    for (int i = 0; i < 9; i++) begin
      look($sformatf("R2 R3 R4 vector %0d", i), VEC[i][33:26], VEC[i][25:24], VEC[i][23:12],
           VEC[i][11], VEC[i][10], VEC[i][9:0]);
    end
    check("R11 counts after table", {hit_count, miss_count, evict_count}, {4'd4, 4'd2, 4'd0});

    // R7: fill at N-1 clears bits set by the table; next victim is slot 0 (page 10)
    fill(8'h13, 10'h103, 3'b111);
    check("R5 no eviction below full", evict_count, 4'd0);
    fill(8'h14, 10'h104, 3'b111);
    look("R7 page 10 evicted after bulk clear", 8'h10, 2'd1, 12'h0, 1'b0, 1'b0, '0);
    look("R7 page 13 retained", 8'h13, 2'd1, 12'h004, 1'b1, 1'b0, 10'h103);

    // R8: hit on page 14 (slot 0) -> victim is slot 1 (page 11)
    look("R8 page 14 present", 8'h14, 2'd0, 12'h100, 1'b1, 1'b0, 10'h104);
    fill(8'h15, 10'h105, 3'b111);
    look("R8 lowest clear slot evicted", 8'h11, 2'd1, 12'h0, 1'b0, 1'b0, '0);

    // R6: hit page 14 then page 13 on full buffer -> page 14 bit cleared, it is evicted
    look("R6 page 14 hit", 8'h14, 2'd1, 12'h0, 1'b1, 1'b0, 10'h104);
    look("R6 page 13 hit", 8'h13, 2'd1, 12'h0, 1'b1, 1'b0, 10'h103);
    fill(8'h16, 10'h106, 3'b111);
    look("R6 page 14 evicted after clearing", 8'h14, 2'd1, 12'h0, 1'b0, 1'b0, '0);
    look("R6 page 15 remains", 8'h15, 2'd1, 12'h0, 1'b1, 1'b0, 10'h105);

    // R10: slot0=16 hit, then same-cycle hit on 13 (slot 3) with fill 17 (victim slot 1)
    look("R10 prep page 16", 8'h16, 2'd1, 12'h0, 1'b1, 1'b0, 10'h106);
    @(negedge clk);
    drive_look(8'h13, 2'd1, 12'hABC);
    fill_en = 1; fill_vpn = 8'h17; fill_pfn = 10'h107; fill_perm = 3'b111;
    #2 check("R10 lookup output during fill", {lk_hit, lk_fault, lk_pfn, lk_paddr},
             pack_exp(1'b1, 1'b0, 10'h103, 12'hABC));
    @(posedge clk); #1 begin lk_valid = 0; fill_en = 0; end
    fill(8'h19, 10'h109, 3'b111);
    look("R10 dropped update: page 17 evicted", 8'h17, 2'd1, 12'h0, 1'b0, 1'b0, '0);
    look("R10 page 16 kept", 8'h16, 2'd1, 12'h0, 1'b1, 1'b0, 10'h106);
    check("R11 eviction count", evict_count, 4'd5);

    // R9: invalidate page 12, reuse its slot without eviction
    inval(8'h12);
    look("R9 invalidated page misses", 8'h12, 2'd2, 12'h0, 1'b0, 1'b0, '0);
    fill(8'h18, 10'h108, 3'b001);
    look("R9 refilled slot hits", 8'h18, 2'd1, 12'h321, 1'b1, 1'b0, 10'h108);
    check("R9 no eviction on reuse", evict_count, 4'd5);

    // R5: refill resident page in place
    fill(8'h19, 10'h1AA, 3'b001);
    look("R5 resident refill new frame", 8'h19, 2'd1, 12'h00F, 1'b1, 1'b0, 10'h1AA);
    look("R5 resident refill new flags", 8'h19, 2'd2, 12'h00F, 1'b0, 1'b1, '0);
    check("R5 refill evicts nothing", evict_count, 4'd5);

    // R11: saturation
    for (int i = 0; i < 20; i++) look("R11 miss burst", 8'h77, 2'd1, 12'h0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 20; i++) look("R11 hit burst", 8'h18, 2'd3, 12'h0, 1'b1, 1'b0, 10'h108);
    check("R11 miss saturates", miss_count, 4'hF);
    check("R11 hit saturates", hit_count, 4'hF);

    // R1: reset again mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1 counters cleared by reset", {hit_count, miss_count, evict_count}, '0);
    look("R1 entries cleared by reset", 8'h16, 2'd1, 12'h0, 1'b0, 1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule